// File: doc/BRIEF.md
# SMI Status Aggregation Register Block

This block gathers interrupt requests from eight peripheral sources into two 8-bit system-management status registers. A set of per-bit enables chooses which of those requests may pull the active-low SMI output. The SMI request can also be forwarded to a serial IRQ request line. The same byte-wide register port also carries a pin-multiplex register and a sticky force-disk-change register.

Most status bits are registered copies of their source levels, and only the source can clear them. The IR activity bit is different. It is captured from any transition on the IR receive input after a synchronizer, and a read of the second status register clears it. When an IR edge and that read arrive in the same cycle, the edge wins. The keyboard-controller P1.2 request reaches SMI only through a dedicated route enable. The force-change bit can be set by software, and only reset clears it.

Top module: `smi_agg`

Register map (8-bit address): 0xB2 control (bit 4 routes P1.2 to SMI, bit 6 forwards SMI to serial IRQ), 0xB4 enable 1, 0xB5 enable 2, 0xB6 status 1, 0xB7 status 2, 0xC0 pin multiplex, 0xC1 force change. In each enable register, an enable bit sits at the same position as the status bit it gates.

## Requirements
- R1: While rst is high and after its release, before any write: both status registers, both enables and control read 0x00, pin multiplex reads 0x02, force change reads 0x00, smi_n is 1 and sirq_smi is 0.
- R2: Status 1 (0xB6) shows src_par in bit 1, src_uart2 in bit 2, src_uart1 in bit 3, src_fdc in bit 4 and src_wdt in bit 7, one clock after the source level. Bits 0, 5 and 6 read 0.
- R3: Status 2 (0xB7) shows src_mouse in bit 0, src_kbd in bit 1 and src_p12 in bit 4, one clock after the source level. Bits 3, 5, 6 and 7 read 0.
- R4: Writes to 0xB6 and 0xB7 do not change any status bit.
- R5: Either direction of change on ir_rx sets status 2 bit 2, and the bit is readable after the third rising clock edge following the change.
- R6: A read strobe at 0xB7 returns the current status 2 value, including bit 2, and clears bit 2 at that clock edge.
- R7: If an IR edge reaches the flag in the same cycle as a read of 0xB7, bit 2 stays set after that edge.
- R8: smi_n is 0 exactly when an enabled status bit is 1. Enable 1 gates bits 1, 2, 3, 4 and 7 of status 1. Enable 2 gates bits 0..2 of status 2. Enable 2 bits 3..7 are reserved, are not stored and read 0.
- R9: Status 2 bit 4 (P1.2) asserts SMI only when control bit 4 is 1.
- R10: sirq_smi is 1 exactly when smi_n is 0 and control bit 6 is 1. Other control bits read 0.
- R11: Writing 1 to bit 0 of 0xC1 sets force_chg. Writing 0 does not clear it, and only rst clears it.
- R12: Pin multiplex bit 1 drives dma3_sel and bit 3 drives kbc_sel. Only these bits are writable, and the rest read 0.
- R13: rd_data is 0x00 when rd_en is low or when the address is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears IR flag at 0xB7) |
| rd_data | output | 8 | Read data |
| src_par | input | 1 | Parallel port request level |
| src_uart2 | input | 1 | Second UART request level |
| src_uart1 | input | 1 | First UART request level |
| src_fdc | input | 1 | Floppy controller request level |
| src_wdt | input | 1 | Watchdog timer request level |
| src_mouse | input | 1 | Mouse request level |
| src_kbd | input | 1 | Keyboard request level |
| src_p12 | input | 1 | Keyboard-controller P1.2 level |
| ir_rx | input | 1 | Selected IR receive input (asynchronous) |
| smi_n | output | 1 | Active-low SMI |
| sirq_smi | output | 1 | SMI request toward the serial IRQ line |
| dma3_sel | output | 1 | Pin-multiplex DMA 3 select |
| kbc_sel | output | 1 | Pin-multiplex keyboard-controller select |
| force_chg | output | 1 | Sticky force-disk-change bit |

## Verification
The bench builds the block with its default parameters: a two-stage IR synchronizer and the default register addresses. With these values, the delay from an IR pin change to the flag is fixed at three edges. The bench can therefore place an IR edge in exactly the cycle of a status 2 read and observe that the edge wins. Reserved bits, ignored writes and the P1.2 route gate are each checked through read data, smi_n or sirq_smi.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;

    localparam int DW = 8;
    localparam int AW = 8;

    localparam logic [DW-1:0] STS1_MASK  = 8'h9E;
    localparam logic [DW-1:0] STS2_MASK  = 8'h17;
    localparam logic [DW-1:0] EN1_MASK   = 8'h9E;
    localparam logic [DW-1:0] EN2_MASK   = 8'h07;
    localparam logic [DW-1:0] CTRL_MASK  = 8'h50;
    localparam logic [DW-1:0] PMUX_MASK  = 8'h0A;
    localparam logic [DW-1:0] PMUX_RESET = 8'h02;

    localparam int IR_BIT        = 2;
    localparam int P12_BIT       = 4;
    localparam int CTRL_P12_BIT  = 4;
    localparam int CTRL_SIRQ_BIT = 6;

    typedef struct packed {
        logic par;
        logic uart2;
        logic uart1;
        logic fdc;
        logic wdt;
        logic mouse;
        logic kbd;
        logic p12;
    } src_t;

    function automatic logic [DW-1:0] pack_sts1(input src_t s);
        logic [DW-1:0] r;
        r    = '0;
        r[1] = s.par;
        r[2] = s.uart2;
        r[3] = s.uart1;
        r[4] = s.fdc;
        r[7] = s.wdt;
        return r;
    endfunction

    function automatic logic [DW-1:0] pack_sts2_level(input src_t s);
        logic [DW-1:0] r;
        r          = '0;
        r[0]       = s.mouse;
        r[1]       = s.kbd;
        r[P12_BIT] = s.p12;
        return r;
    endfunction

endpackage

// File: rtl/smi_agg_sync.sv
module smi_agg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/smi_agg_status.sv
module smi_agg_status
    import smi_agg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  src_t          src,
    input  logic          ir_s,
    input  logic          rd_clr,
    output logic [DW-1:0] sts1,
    output logic [DW-1:0] sts2
);
    logic [DW-1:0] sts1_q;
    logic [DW-1:0] lvl2_q;
    logic          ir_prev;
    logic          ir_flag;
    logic          ir_edge;

    assign ir_edge = ir_s ^ ir_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts1_q  <= '0;
            lvl2_q  <= '0;
            ir_prev <= 1'b0;
            ir_flag <= 1'b0;
        end else begin
            sts1_q  <= pack_sts1(src);
            lvl2_q  <= pack_sts2_level(src);
            ir_prev <= ir_s;
            if (ir_edge)     ir_flag <= 1'b1;
            else if (rd_clr) ir_flag <= 1'b0;
        end
    end

    always_comb begin
        sts1         = sts1_q & STS1_MASK;
        sts2         = lvl2_q & STS2_MASK;
        sts2[IR_BIT] = ir_flag;
    end

    a_r5_ir_set: assert property (@(posedge clk) disable iff (rst)
        ir_edge |=> sts2[IR_BIT]);
    a_r6_ir_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !ir_edge) |=> !sts2[IR_BIT]);
    a_r7_edge_wins: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && ir_edge) |=> sts2[IR_BIT]);
    a_r2_wdt_level: assert property (@(posedge clk) disable iff (rst)
        src.wdt |=> sts1[7]);
    a_r3_kbd_level: assert property (@(posedge clk) disable iff (rst)
        src.kbd |=> sts2[1]);
endmodule

// File: rtl/smi_agg_regs.sv
module smi_agg_regs
    import smi_agg_pkg::*;
#(
    parameter logic [AW-1:0] A_CTRL  = 8'hB2,
    parameter logic [AW-1:0] A_EN1   = 8'hB4,
    parameter logic [AW-1:0] A_EN2   = 8'hB5,
    parameter logic [AW-1:0] A_PMUX  = 8'hC0,
    parameter logic [AW-1:0] A_FORCE = 8'hC1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] en1,
    output logic [DW-1:0] en2,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] pmux,
    output logic          force_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en1     <= '0;
            en2     <= '0;
            ctrl    <= '0;
            pmux    <= PMUX_RESET;
            force_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_EN1)  en1  <= wr_data & EN1_MASK;
            if (addr == A_EN2)  en2  <= wr_data & EN2_MASK;
            if (addr == A_CTRL) ctrl <= wr_data & CTRL_MASK;
            if (addr == A_PMUX) pmux <= wr_data & PMUX_MASK;
            if (addr == A_FORCE && wr_data[0]) force_q <= 1'b1;
        end
    end

    a_r11_force_sticky: assert property (@(posedge clk) disable iff (rst)
        force_q |=> force_q);
    a_r11_force_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_FORCE && wr_data[0]) |=> force_q);
endmodule

// File: rtl/smi_agg.sv
module smi_agg
    import smi_agg_pkg::*;
#(
    parameter int            SYNC_STAGES = 2,
    parameter logic [AW-1:0] A_CTRL      = 8'hB2,
    parameter logic [AW-1:0] A_EN1       = 8'hB4,
    parameter logic [AW-1:0] A_EN2       = 8'hB5,
    parameter logic [AW-1:0] A_STS1      = 8'hB6,
    parameter logic [AW-1:0] A_STS2      = 8'hB7,
    parameter logic [AW-1:0] A_PMUX      = 8'hC0,
    parameter logic [AW-1:0] A_FORCE     = 8'hC1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    input  logic       src_par,
    input  logic       src_uart2,
    input  logic       src_uart1,
    input  logic       src_fdc,
    input  logic       src_wdt,
    input  logic       src_mouse,
    input  logic       src_kbd,
    input  logic       src_p12,
    input  logic       ir_rx,
    output logic       smi_n,
    output logic       sirq_smi,
    output logic       dma3_sel,
    output logic       kbc_sel,
    output logic       force_chg
);
    src_t          src;
    logic          ir_s;
    logic          rd_clr;
    logic [DW-1:0] sts1, sts2, en1, en2, ctrl, pmux;
    logic          smi_hit;

    assign src = '{par: src_par, uart2: src_uart2, uart1: src_uart1,
                   fdc: src_fdc, wdt: src_wdt, mouse: src_mouse,
                   kbd: src_kbd, p12: src_p12};

    assign rd_clr = rd_en && (addr == A_STS2);

    smi_agg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(ir_rx), .q(ir_s)
    );

    smi_agg_status u_status (
        .clk(clk), .rst(rst), .src(src), .ir_s(ir_s),
        .rd_clr(rd_clr), .sts1(sts1), .sts2(sts2)
    );

    smi_agg_regs #(
        .A_CTRL(A_CTRL), .A_EN1(A_EN1), .A_EN2(A_EN2),
        .A_PMUX(A_PMUX), .A_FORCE(A_FORCE)
    ) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .en1(en1), .en2(en2), .ctrl(ctrl),
        .pmux(pmux), .force_q(force_chg)
    );

    always_comb begin
        smi_hit = (|(sts1 & en1))
                | (|(sts2 & en2))
                | (sts2[P12_BIT] & ctrl[CTRL_P12_BIT]);
    end

    assign smi_n    = ~smi_hit;
    assign sirq_smi = smi_hit & ctrl[CTRL_SIRQ_BIT];
    assign dma3_sel = pmux[1];
    assign kbc_sel  = pmux[3];

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL:  rd_data = ctrl;
                A_EN1:   rd_data = en1;
                A_EN2:   rd_data = en2;
                A_STS1:  rd_data = sts1;
                A_STS2:  rd_data = sts2;
                A_PMUX:  rd_data = pmux;
                A_FORCE: rd_data = {7'd0, force_chg};
                default: rd_data = '0;
            endcase
        end
    end

    a_r10_sirq_needs_smi: assert property (@(posedge clk) disable iff (rst)
        sirq_smi |-> !smi_n);
    a_r9_p12_routed: assert property (@(posedge clk) disable iff (rst)
        (sts2[P12_BIT] && ctrl[CTRL_P12_BIT]) |-> !smi_n);
    a_r13_idle_read: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == 8'h00));
endmodule

// File: tb/smi_agg_tb.sv
module smi_agg_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic src_par = 0, src_uart2 = 0, src_uart1 = 0, src_fdc = 0, src_wdt = 0;
    logic src_mouse = 0, src_kbd = 0, src_p12 = 0, ir_rx = 0;
    logic smi_n, sirq_smi, dma3_sel, kbc_sel, force_chg;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smi_agg u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .src_par(src_par), .src_uart2(src_uart2), .src_uart1(src_uart1),
        .src_fdc(src_fdc), .src_wdt(src_wdt), .src_mouse(src_mouse),
        .src_kbd(src_kbd), .src_p12(src_p12), .ir_rx(ir_rx),
        .smi_n(smi_n), .sirq_smi(sirq_smi), .dma3_sel(dma3_sel),
        .kbc_sel(kbc_sel), .force_chg(force_chg)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // All tasks start just after a falling edge and end on one.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 smi_n in reset", {7'd0, smi_n}, 8'h01);
        rst = 1'b0;
        @(negedge clk);
        rd(8'hB6, v); check("R1 sts1", v, 8'h00);
        rd(8'hB7, v); check("R1 sts2", v, 8'h00);
        rd(8'hB4, v); check("R1 en1", v, 8'h00);
        rd(8'hB5, v); check("R1 en2", v, 8'h00);
        rd(8'hB2, v); check("R1 ctrl", v, 8'h00);
        rd(8'hC0, v); check("R1 pmux", v, 8'h02);
        rd(8'hC1, v); check("R1 force", v, 8'h00);
        check("R1 smi_n", {7'd0, smi_n}, 8'h01);
        check("R1 sirq", {7'd0, sirq_smi}, 8'h00);
    endtask

    task automatic t_status_layout();
        logic [7:0] v;
        src_par = 1; src_uart1 = 1; src_wdt = 1; src_kbd = 1; src_p12 = 1;
        @(negedge clk);
        rd(8'hB6, v); check("R2 sts1 mix a", v, 8'h8A);
        rd(8'hB7, v); check("R3 sts2 mix a", v, 8'h12);
        src_par = 0; src_uart1 = 0; src_wdt = 0; src_kbd = 0; src_p12 = 0;
        src_uart2 = 1; src_fdc = 1; src_mouse = 1;
        @(negedge clk);
        rd(8'hB6, v); check("R2 sts1 mix b", v, 8'h14);
        rd(8'hB7, v); check("R3 sts2 mix b", v, 8'h01);
        src_uart2 = 0; src_fdc = 0; src_mouse = 0;
        @(negedge clk);
        rd(8'hB6, v); check("R2 sts1 follows source low", v, 8'h00);
    endtask

    task automatic t_status_write();
        logic [7:0] v;
        wr(8'hB6, 8'hFF); wr(8'hB7, 8'hFF);
        rd(8'hB6, v); check("R4 sts1 write ignored", v, 8'h00);
        rd(8'hB7, v); check("R4 sts2 write ignored", v, 8'h00);
        src_fdc = 1;
        @(negedge clk);
        wr(8'hB6, 8'h00);
        rd(8'hB6, v); check("R4 sts1 not cleared by write", v, 8'h10);
        src_fdc = 0;
        @(negedge clk);
    endtask

    task automatic t_ir();
        logic [7:0] v;
        ir_rx = 1;
        repeat (3) @(negedge clk);
        rd(8'hB7, v); check("R5 ir rise sets flag", v, 8'h04);
        rd(8'hB7, v); check("R6 read clears flag", v, 8'h00);
        ir_rx = 0;
        repeat (3) @(negedge clk);
        rd(8'hB6, v); check("R6 other read keeps flag", v, 8'h00);
        rd(8'hB7, v); check("R5 ir fall sets flag", v, 8'h04);
        rd(8'hB7, v); check("R6 flag cleared", v, 8'h00);
        // Edge reaches the flag on the same edge as the clearing read
        ir_rx = 1;
        repeat (2) @(negedge clk);
        rd(8'hB7, v); check("R7 read before flag", v, 8'h00);
        rd(8'hB7, v); check("R7 edge wins over read", v, 8'h04);
        rd(8'hB7, v); check("R7 later read clears", v, 8'h00);
    endtask

    task automatic t_smi();
        logic [7:0] v;
        wr(8'hB4, 8'hFF);
        rd(8'hB4, v); check("R8 en1 reserved bits", v, 8'h9E);
        check("R8 enabled but idle", {7'd0, smi_n}, 8'h01);
        src_uart1 = 1;
        @(negedge clk);
        check("R8 uart1 enabled -> smi", {7'd0, smi_n}, 8'h00);
        wr(8'hB4, 8'h80);
        check("R8 uart1 masked", {7'd0, smi_n}, 8'h01);
        src_uart1 = 0; src_wdt = 1;
        @(negedge clk);
        check("R8 wdt enabled -> smi", {7'd0, smi_n}, 8'h00);
        src_wdt = 0;
        @(negedge clk);
        check("R8 source gone", {7'd0, smi_n}, 8'h01);
        wr(8'hB4, 8'h00);
        wr(8'hB5, 8'hFF);
        rd(8'hB5, v); check("R8 en2 reserved bits", v, 8'h07);
        src_mouse = 1;
        @(negedge clk);
        check("R8 mouse enabled -> smi", {7'd0, smi_n}, 8'h00);
        src_mouse = 0;
        @(negedge clk);
        ir_rx = 0;
        repeat (3) @(negedge clk);
        check("R8 ir flag enabled -> smi", {7'd0, smi_n}, 8'h00);
        rd(8'hB7, v);
        check("R8 ir cleared -> smi off", {7'd0, smi_n}, 8'h01);
    endtask

    task automatic t_p12_sirq();
        logic [7:0] v;
        src_p12 = 1;
        @(negedge clk);
        check("R9 p12 without route", {7'd0, smi_n}, 8'h01);
        wr(8'hB2, 8'hFF);
        rd(8'hB2, v); check("R10 ctrl reserved bits", v, 8'h50);
        check("R9 p12 routed", {7'd0, smi_n}, 8'h00);
        check("R10 sirq forwarded", {7'd0, sirq_smi}, 8'h01);
        wr(8'hB2, 8'h10);
        check("R10 sirq off with smi on", {7'd0, sirq_smi}, 8'h00);
        wr(8'hB2, 8'h40);
        check("R10 sirq off with smi off", {7'd0, sirq_smi}, 8'h00);
        check("R9 route off", {7'd0, smi_n}, 8'h01);
        src_p12 = 0;
        wr(8'hB2, 8'h00);
        wr(8'hB5, 8'h00);
    endtask

    task automatic t_force_pmux();
        logic [7:0] v;
        wr(8'hC1, 8'h01);
        check("R11 force set", {7'd0, force_chg}, 8'h01);
        wr(8'hC1, 8'h00);
        rd(8'hC1, v); check("R11 write 0 keeps force", v, 8'h01);
        wr(8'hC0, 8'hFF);
        rd(8'hC0, v); check("R12 pmux mask", v, 8'h0A);
        check("R12 selects", {6'd0, kbc_sel, dma3_sel}, 8'h03);
        wr(8'hC0, 8'h08);
        check("R12 dma3 cleared", {6'd0, kbc_sel, dma3_sel}, 8'h02);
        rd(8'hA5, v); check("R13 unmapped read", v, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 reset clears force", {7'd0, force_chg}, 8'h00);
        check("R12 reset dma3", {6'd0, kbc_sel, dma3_sel}, 8'h01);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_status_layout();
        t_status_write();
        t_ir();
        t_smi();
        t_p12_sirq();
        t_force_pmux();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule